// File: doc/BRIEF.md
# DMA Descriptor Address and Count Engine

This block drives one DMA channel through a cycle that a single descriptor defines. The descriptor supplies a fixed end pointer, a remaining-count field that holds the number of transfers minus one, an increment code, a burst exponent R and a cycle-control field. While the cycle is running, the block presents the address of the next transfer. It computes that address backwards from the end pointer: the remaining count is shifted left by the increment code and subtracted from the end pointer. The last transfer therefore lands exactly on the end pointer.

The bus side reports each finished transfer with `xfer_ack_i`. On every acknowledge the count goes down by one. After every 2^R transfers the block emits a one-cycle write-back of the remaining count, so the descriptor can be re-armed from memory. When the transfer at count zero finishes, the block writes the descriptor back in its invalid form (count 0, cycle control 0), pulses `done_o` and returns to idle. A done flag and an error flag are held until software clears them, and each is gated by its own enable into one interrupt line.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset `active_o`, `wb_valid_o`, `done_o`, `irq_flags_o` and `irq_o` are 0, and the stored cycle-control field is 0.
- R2: While active, `addr_o` equals end pointer − (count << inc), modulo 2^AW. The inc codes are 00 byte (shift 0), 01 halfword (shift 1) and 10 word (shift 2). The first address uses count = n_minus_1.
- R3: Each `xfer_ack_i` while active lowers the count by one, so successive addresses rise by 1 << inc. The acknowledge given at count 0 ends the cycle: `done_o` pulses high for one cycle and `active_o` falls in the same cycle.
- R4: With inc code 11, `addr_o` equals the end pointer for every transfer of the cycle.
- R5: After each 2^R acknowledges that do not end the cycle, `wb_valid_o` pulses for one cycle. In that cycle `wb_count_o` holds the count that remains after the decrement, and `wb_cycle_o` holds the unchanged cycle-control field.
- R6: The acknowledge that ends the cycle produces a single write-back with `wb_count_o` = 0 and `wb_cycle_o` = 0, even when it also falls on a burst boundary. The stored descriptor is then invalid, so a new start without a reload is treated as in R7.
- R7: When the stored cycle-control field is 0, `start_i` is ignored (`active_o` stays 0) and the error flag, `irq_flags_o[1]`, is set.
- R8: Flags are sticky. Bit 0 is done and bit 1 is error. A 1 on `irq_clr_i[k]` clears flag k, but a set event in the same cycle wins and the flag stays 1.
- R9: `irq_o` is the OR over k of `irq_flags_o[k] & irq_en_i[k]`.
- R10: While idle, `xfer_ack_i` has no effect: it produces no write-back and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_load_i | input | 1 | Capture the descriptor fields (ignored while active) |
| desc_end_i | input | AW | End pointer |
| desc_count_i | input | CW | Transfers minus one |
| desc_inc_i | input | 2 | Increment code |
| desc_rpow_i | input | RW | Burst exponent R |
| desc_cycle_i | input | 3 | Cycle control; 0 means invalid |
| start_i | input | 1 | Begin a cycle from the stored descriptor |
| xfer_ack_i | input | 1 | One transfer finished |
| irq_en_i | input | 2 | Flag enables (bit 0 done, bit 1 error) |
| irq_clr_i | input | 2 | Write-one-to-clear strobes for the flags |
| active_o | output | 1 | Cycle in progress |
| addr_o | output | AW | Address of the current transfer |
| wb_valid_o | output | 1 | Descriptor write-back pulse |
| wb_count_o | output | CW | Count written back |
| wb_cycle_o | output | 3 | Cycle control written back |
| done_o | output | 1 | Cycle completion pulse |
| irq_flags_o | output | 2 | Sticky flags (bit 0 done, bit 1 error) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle. First, a burst write-back and the completion write-back can coincide: with n_minus_1 = 7 and R = 3, or n_minus_1 = 3 and R = 1, the final acknowledge is also the 2^R-th of its burst. The bench expects exactly one write-back pulse carrying count 0 and cycle control 0. Second, a flag can be set and cleared in the same cycle: the bench drives an invalid start together with a clear strobe on the error flag and expects the flag to remain set.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  typedef enum logic [1:0] {
    INC_BYTE = 2'b00,
    INC_HALF = 2'b01,
    INC_WORD = 2'b10,
    INC_NONE = 2'b11
  } inc_e;

  localparam int unsigned FLAG_DONE = 0;
  localparam int unsigned FLAG_ERR  = 1;
  localparam int unsigned NFLAGS    = 2;
  localparam int unsigned CYC_W     = 3;
endpackage

// File: rtl/dma_addr_calc.sv
module dma_addr_calc
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 10
) (
  input  logic [AW-1:0] end_i,
  input  logic [CW-1:0] count_i,
  input  inc_e          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] cnt_ext;
  logic [AW-1:0] offset;

  assign cnt_ext = AW'(count_i);

  always_comb begin
    unique case (inc_i)
      INC_BYTE: offset = cnt_ext;
      INC_HALF: offset = cnt_ext << 1;
      INC_WORD: offset = cnt_ext << 2;
      default:  offset = '0;  // no increment: shift bypassed
    endcase
  end

  assign addr_o = end_i - offset;
endmodule

// File: rtl/dma_burst_ctr.sv
module dma_burst_ctr #(
  parameter int unsigned CW = 10,
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [RW-1:0] rpow_i,
  output logic          hit_o
);
  localparam int unsigned BW = CW + 1;

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_nxt;
  logic [BW-1:0] limit;

  assign cnt_nxt = cnt_q + BW'(1);
  assign limit   = BW'(1) << rpow_i;  // overflows to 0 for large R: never hit
  assign hit_o   = step_i && (cnt_nxt == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clear_i || hit_o)   cnt_q <= '0;
    else if (step_i)             cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int unsigned NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q;

  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[k] <= 1'b0;
      else if (set_i[k])  flags_q[k] <= 1'b1;  // set beats clear
      else if (clr_i[k])  flags_q[k] <= 1'b0;
    end

    // R8
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flags_q[k]);

    // R8
    flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !flags_q[k]);

    // R8
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && flags_q[k]) |=> flags_q[k]);
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 10,
  parameter int unsigned RW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_load_i,
  input  logic [AW-1:0]     desc_end_i,
  input  logic [CW-1:0]     desc_count_i,
  input  logic [1:0]        desc_inc_i,
  input  logic [RW-1:0]     desc_rpow_i,
  input  logic [CYC_W-1:0]  desc_cycle_i,
  input  logic              start_i,
  input  logic              xfer_ack_i,
  input  logic [NFLAGS-1:0] irq_en_i,
  input  logic [NFLAGS-1:0] irq_clr_i,
  output logic              active_o,
  output logic [AW-1:0]     addr_o,
  output logic              wb_valid_o,
  output logic [CW-1:0]     wb_count_o,
  output logic [CYC_W-1:0]  wb_cycle_o,
  output logic              done_o,
  output logic [NFLAGS-1:0] irq_flags_o,
  output logic              irq_o
);
  logic [AW-1:0]    end_q;
  logic [CW-1:0]    dcnt_q;
  inc_e             inc_q;
  logic [RW-1:0]    rpow_q;
  logic [CYC_W-1:0] cyc_q;

  logic             active_q;
  logic [CW-1:0]    cnt_q;
  logic             wb_valid_q, done_q;
  logic [CW-1:0]    wb_count_q;
  logic [CYC_W-1:0] wb_cycle_q;

  logic go, bad_start, ack, last, step, burst_hit;
  logic [NFLAGS-1:0] flag_set;

  assign ack       = active_q && xfer_ack_i;
  assign last      = ack && (cnt_q == '0);
  assign step      = ack && !last;
  assign go        = start_i && !active_q && (cyc_q != '0);
  assign bad_start = start_i && !active_q && (cyc_q == '0);

  // descriptor store
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q  <= '0;
      dcnt_q <= '0;
      inc_q  <= INC_BYTE;
      rpow_q <= '0;
      cyc_q  <= '0;
    end else if (desc_load_i && !active_q) begin
      end_q  <= desc_end_i;
      dcnt_q <= desc_count_i;
      inc_q  <= inc_e'(desc_inc_i);
      rpow_q <= desc_rpow_i;
      cyc_q  <= desc_cycle_i;
    end else if (last) begin
      dcnt_q <= '0;
      cyc_q  <= '0;  // invalidate
    end else if (burst_hit) begin
      dcnt_q <= cnt_q - CW'(1);
    end
  end

  // working count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      cnt_q    <= dcnt_q;
    end else if (last) begin
      active_q <= 1'b0;
    end else if (step) begin
      cnt_q    <= cnt_q - CW'(1);
    end
  end

  // write-back and completion pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_q <= 1'b0;
      wb_count_q <= '0;
      wb_cycle_q <= '0;
      done_q     <= 1'b0;
    end else begin
      wb_valid_q <= last || burst_hit;
      done_q     <= last;
      if (last) begin
        wb_count_q <= '0;
        wb_cycle_q <= '0;
      end else if (burst_hit) begin
        wb_count_q <= cnt_q - CW'(1);
        wb_cycle_q <= cyc_q;
      end
    end
  end

  dma_burst_ctr #(.CW(CW), .RW(RW)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (go),
    .step_i  (step),
    .rpow_i  (rpow_q),
    .hit_o   (burst_hit)
  );

  dma_addr_calc #(.AW(AW), .CW(CW)) u_addr (
    .end_i   (end_q),
    .count_i (cnt_q),
    .inc_i   (inc_q),
    .addr_o  (addr_o)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_DONE] = last;
    flag_set[FLAG_ERR]  = bad_start;
  end

  dma_irq_flags #(.NF(NFLAGS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (irq_clr_i),
    .en_i    (irq_en_i),
    .flags_o (irq_flags_o),
    .irq_o   (irq_o)
  );

  assign active_o   = active_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_count_o = wb_count_q;
  assign wb_cycle_o = wb_cycle_q;
  assign done_o     = done_q;

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q);

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && inc_q != INC_NONE) |=> (addr_o - $past(addr_o)) == (AW'(1) << $past(inc_q)));

  // R4
  addr_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && inc_q == INC_NONE) |=> $stable(addr_o));

  // R6
  final_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (wb_valid_q && wb_count_q == '0 && wb_cycle_q == '0));

  // R7
  bad_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_start |=> (!active_q && irq_flags_o[FLAG_ERR]));

  // R10
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !go) |=> (!wb_valid_q && !done_q));
endmodule

// File: tb/sim_dma_desc_engine.sv
module sim_dma_desc_engine;
  localparam int AW = 16;
  localparam int CW = 10;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          desc_load = 1'b0;
  logic [AW-1:0] desc_end = '0;
  logic [CW-1:0] desc_count = '0;
  logic [1:0]    desc_inc = '0;
  logic [RW-1:0] desc_rpow = '0;
  logic [2:0]    desc_cycle = '0;
  logic          start = 1'b0;
  logic          ack = 1'b0;
  logic [1:0]    irq_en = '0;
  logic [1:0]    irq_clr = '0;
  logic          active, wb_valid, done, irq;
  logic [AW-1:0] addr;
  logic [CW-1:0] wb_count;
  logic [2:0]    wb_cycle;
  logic [1:0]    flags;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_desc_engine #(.AW(AW), .CW(CW), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_load_i(desc_load), .desc_end_i(desc_end), .desc_count_i(desc_count),
    .desc_inc_i(desc_inc), .desc_rpow_i(desc_rpow), .desc_cycle_i(desc_cycle),
    .start_i(start), .xfer_ack_i(ack), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .active_o(active), .addr_o(addr), .wb_valid_o(wb_valid), .wb_count_o(wb_count),
    .wb_cycle_o(wb_cycle), .done_o(done), .irq_flags_o(flags), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_desc(input int e, input int n, input int inc, input int r, input int cyc);
    desc_load = 1'b1; desc_end = AW'(e); desc_count = CW'(n);
    desc_inc = 2'(inc); desc_rpow = RW'(r); desc_cycle = 3'(cyc);
    tick();
    desc_load = 1'b0;
  endtask

  // full cycle with expected values derived from the requirements
  task automatic run_desc(input int e, input int n, input int inc, input int r, input int cyc);
    int b = 0;
    load_desc(e, n, inc, r, cyc);
    start = 1'b1; tick(); start = 1'b0;
    check(active == 1'b1, "R2 active after start", int'(active), 1);
    for (int k = n; k >= 0; k--) begin
      int ea = (inc == 3) ? e : ((e - (k << inc)) & 16'hFFFF);
      check(addr == AW'(ea), (inc == 3) ? "R4 fixed addr" : "R2 addr", int'(addr), ea);
      ack = 1'b1; tick(); ack = 1'b0;
      if (k == 0) begin
        check(done == 1'b1 && active == 1'b0, "R3 done/idle", {int'(done), int'(active)}, 2);
        check(wb_valid && wb_count == 0 && wb_cycle == 0, "R6 final write-back",
              int'(wb_count) | (int'(wb_cycle) << 16), 0);
      end else begin
        b++;
        check(done == 1'b0, "R3 no early done", int'(done), 0);
        if (b == (1 << r)) begin
          b = 0;
          check(wb_valid && wb_count == CW'(k - 1) && wb_cycle == 3'(cyc), "R5 burst write-back",
                int'(wb_count), k - 1);
        end else begin
          check(wb_valid == 1'b0, "R5 no write-back mid burst", int'(wb_valid), 0);
        end
      end
    end
    tick();
    check(done == 1'b0 && wb_valid == 1'b0, "R3 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    check(active == 0 && wb_valid == 0 && done == 0, "R1 reset outputs", int'(active), 0);
    check(flags == 0 && irq == 0, "R1 reset flags", int'(flags), 0);
    start = 1'b1; tick(); start = 1'b0;
    check(active == 0 && flags[1] == 1'b1, "R1 R7 reset descriptor invalid", int'(flags), 2);
    irq_clr = 2'b11; tick(); irq_clr = '0;
    check(flags == 0, "R8 clear", int'(flags), 0);
  endtask

  task automatic t_halfword();
    run_desc(16'h05E7, 11, 1, 3, 1);
    check(flags[0] == 1'b1, "R8 done flag set", int'(flags), 1);
    check(irq == 1'b0, "R9 masked", int'(irq), 0);
    irq_en = 2'b01; #1;
    check(irq == 1'b1, "R9 enabled done", int'(irq), 1);
    start = 1'b1; tick(); start = 1'b0;
    check(active == 0 && flags[1] == 1'b1, "R6 R7 restart invalid", int'(flags), 3);
    irq_clr = 2'b11; tick(); irq_clr = '0; irq_en = '0;
    check(flags == 0 && irq == 0, "R8 flags cleared", int'(flags), 0);
  endtask

  task automatic t_coincide();
    run_desc(16'h1000, 3, 0, 1, 2);
    run_desc(16'h0003, 7, 2, 3, 5);  // wraps below zero
    irq_clr = 2'b01; tick(); irq_clr = '0;
  endtask

  task automatic t_fixed();
    run_desc(16'h4242, 2, 3, 0, 1);
    irq_clr = 2'b01; tick(); irq_clr = '0;
  endtask

  task automatic t_idle_ack();
    ack = 1'b1; tick(); ack = 1'b0;
    check(wb_valid == 0 && done == 0 && active == 0, "R10 idle ack ignored", int'(wb_valid), 0);
  endtask

  task automatic t_set_clr();
    load_desc(16'h0100, 1, 0, 0, 0);
    irq_en = 2'b10;
    start = 1'b1; irq_clr = 2'b10; tick(); start = 1'b0; irq_clr = '0;
    check(flags[1] == 1'b1, "R8 set wins over clear", int'(flags), 2);
    check(active == 1'b0, "R7 start ignored", int'(active), 0);
    check(irq == 1'b1, "R9 error irq", int'(irq), 1);
    irq_clr = 2'b10; tick(); irq_clr = '0;
    check(irq == 1'b0 && flags == 0, "R9 irq drops", int'(irq), 0);
    irq_en = '0;
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_halfword();
    t_coincide();
    t_fixed();
    t_idle_ack();
    t_set_clr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule